// File: doc/BRIEF.md
# Iterative Min-Sum Decoder for a Two-Dimensional Parity Product Code

This block recovers the data of an N×N product codeword in which every row and every column carries one even-parity bit. It takes one signed soft value per code bit. A positive value favours a 1 and a negative value favours a 0; the size of the value is the confidence. The decoder then alternates two half-iterations. The row half-iteration updates a row-extrinsic array. The column half-iteration updates a column-extrinsic array. Each half-iteration sees only the channel value and the extrinsic value from the other dimension, never its own earlier output. After the programmed number of full iterations it gives a hard decision for every bit.

Each parity code is evaluated with the min-sum rule. For every bit, the sign of its extrinsic value is the product of the signs of the other members of its code. The magnitude is the smallest magnitude among those other members, found with a first-minimum and second-minimum search. Each half-iteration takes one clock, with all rows (or all columns) evaluated in parallel. A frame is loaded word by word after a start pulse. The caller then waits for a single-cycle completion pulse.

Top module: `spc_prod_decoder`

## Requirements
- R1: A start pulse while idle clears both extrinsic arrays and captures the iteration count. The next N×N words presented with llr_valid are stored in row-major order: word k is bit (k/N, k%N) and is reported on hard_out[k].
- R2: The soft value convention is: positive means 1, negative means 0. A soft sum of exactly zero is decided as 0. With an iteration count of 0, hard_out[k] is 1 exactly when word k is greater than zero.
- R3: The extrinsic value for a bit excludes the bit itself. Its sign is negative exactly when an odd number of the other members of the code are negative (zero counts as non-negative). Its magnitude is the minimum magnitude of the other members.
- R4: The row half-iteration takes as input, for each bit, the saturated sum of its channel value and its column-extrinsic value. The column half-iteration takes the saturated sum of the channel value and the new row-extrinsic value. One iteration is a row half-iteration followed by a column half-iteration.
- R5: All stored and exchanged values are 6-bit two's complement and saturate to the range −31..+31. An input of −32 is stored as −31.
- R6: The decision for bit k is 1 exactly when channel + row-extrinsic + column-extrinsic, taken at full precision, is greater than zero.
- R7: done is a one-cycle pulse. It is high in the cycle after the 2·I+1-th rising edge following the edge that stores the last word, where I is the count captured at start. hard_out holds its value until the next decision. After reset, done and hard_out are 0.
- R8: Consider a valid codeword with correct-bit magnitudes in 8..15 and one bit flipped with magnitude 1..15. Such a frame is decoded to the original codeword after one iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new frame when the decoder is idle |
| iters_in | input | ITER_W | Number of full iterations, sampled with start |
| llr_valid | input | 1 | Qualifies llr_in during loading |
| llr_in | input | LLR_W | Signed channel soft value, row-major order |
| done | output | 1 | One-cycle pulse when hard_out is updated |
| hard_out | output | N*N | Hard decisions, bit k is row k/N column k%N |

## Verification
The bound checker watches the control sequence on every cycle. It checks that a row half-iteration is always followed by a column half-iteration, that the iteration counter stays below the captured count, and that the decision step falls exactly when the count is reached. It also checks that both extrinsic arrays are empty right after a start, that no exchanged value ever reaches −32, that done never lasts two cycles, and that hard_out moves only at a decision. The arithmetic itself can only be shown by the bench scenarios. These cover the exclusion of a bit's own value, the rule for which values are exchanged, saturation and the tie-to-zero decision. The bench compares hard decisions against an independently written model over many random frames and iteration counts. It also sweeps every single-error position and several error magnitudes.

// File: rtl/spc_pkg.sv
package spc_pkg;
  parameter int LLR_W   = 6;
  localparam int LLR_MAX = 2 ** (LLR_W - 1) - 1;

  typedef logic signed [LLR_W-1:0] llr_t;
  typedef logic        [LLR_W-2:0] mag_t;
  typedef logic signed [LLR_W+1:0] wide_t;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ROW, S_COL, S_DEC} dec_state_t;

  // clamp a wide sum into the symmetric range
  function automatic llr_t sat_wide(input wide_t s);
    if (s > wide_t'(LLR_MAX))       return llr_t'(LLR_MAX);
    else if (s < wide_t'(-LLR_MAX)) return llr_t'(-LLR_MAX);
    else                            return llr_t'(s);
  endfunction

  function automatic llr_t sat_add(input llr_t a, input llr_t b);
    wide_t s;
    s = wide_t'(a) + wide_t'(b);
    return sat_wide(s);
  endfunction

  function automatic mag_t mag_of(input llr_t v);
    llr_t a;
    a = (v < 0) ? -v : v;
    return a[LLR_W-2:0];
  endfunction

  function automatic llr_t make_llr(input logic neg, input mag_t m);
    llr_t v;
    v = llr_t'({1'b0, m});
    return neg ? -v : v;
  endfunction

  // full-precision three-way sum, 1 only when strictly positive
  function automatic logic decide(input llr_t c, input llr_t a, input llr_t b);
    wide_t s;
    s = wide_t'(c) + wide_t'(a) + wide_t'(b);
    return s > 0;
  endfunction
endpackage

// File: rtl/spc_minsum.sv
module spc_minsum
  import spc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*LLR_W-1:0] v_flat,
  output logic [N*LLR_W-1:0] e_flat
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  mag_t             min1, min2;
  logic [IDX_W-1:0] min1_idx;
  logic             parity;

  always_comb begin
    min1     = '1;
    min2     = '1;
    min1_idx = '0;
    parity   = 1'b0;
    for (int i = 0; i < N; i++) begin
      parity = parity ^ v_flat[i*LLR_W + LLR_W - 1];
      if (mag_of(v_flat[i*LLR_W +: LLR_W]) < min1) begin
        min2     = min1;
        min1     = mag_of(v_flat[i*LLR_W +: LLR_W]);
        min1_idx = IDX_W'(i);
      end else if (mag_of(v_flat[i*LLR_W +: LLR_W]) < min2) begin
        min2 = mag_of(v_flat[i*LLR_W +: LLR_W]);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    logic own_neg;
    mag_t other_min;
    assign own_neg   = v_flat[g*LLR_W + LLR_W - 1];
    assign other_min = (min1_idx == IDX_W'(g)) ? min2 : min1;
    assign e_flat[g*LLR_W +: LLR_W] = make_llr(parity ^ own_neg, other_min);
  end
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
#(
  parameter int N      = 4,
  parameter int ITER_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              llr_valid,
  input  logic [ITER_W-1:0] iters_in,
  output logic              load_go,
  output logic              load_we,
  output logic [$clog2(N*N)-1:0] load_idx,
  output logic              row_step,
  output logic              col_step,
  output logic              dec_step,
  output logic [ITER_W-1:0] it_cnt,
  output logic [ITER_W-1:0] iters_q
);
  localparam int NN    = N * N;
  localparam int CNT_W = $clog2(NN);

  dec_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign load_go  = (state == S_IDLE) && start;
  assign load_we  = (state == S_LOAD) && llr_valid;
  assign load_idx = cnt;
  assign row_step = (state == S_ROW);
  assign col_step = (state == S_COL);
  assign dec_step = (state == S_DEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      it_cnt  <= '0;
      iters_q <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_LOAD;
          cnt     <= '0;
          it_cnt  <= '0;
          iters_q <= iters_in;
        end
        S_LOAD: if (llr_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(NN - 1))
            state <= (iters_q == '0) ? S_DEC : S_ROW;
        end
        S_ROW: state <= S_COL;
        S_COL: begin
          it_cnt <= it_cnt + 1'b1;
          state  <= (it_cnt + 1'b1 == iters_q) ? S_DEC : S_ROW;
        end
        S_DEC:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spc_prod_decoder.sv
module spc_prod_decoder
  import spc_pkg::*;
#(
  parameter int N      = 4,
  parameter int ITER_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ITER_W-1:0] iters_in,
  input  logic              llr_valid,
  input  logic [LLR_W-1:0]  llr_in,
  output logic              done,
  output logic [N*N-1:0]    hard_out
);
  localparam int NN    = N * N;
  localparam int CNT_W = $clog2(NN);

  logic              load_go, load_we, row_step, col_step, dec_step;
  logic [CNT_W-1:0]  load_idx;
  logic [ITER_W-1:0] it_cnt, iters_q;

  llr_t chan  [NN];
  llr_t ext_r [NN];
  llr_t ext_c [NN];

  logic [N*LLR_W-1:0] row_v [N];
  logic [N*LLR_W-1:0] row_e [N];
  logic [N*LLR_W-1:0] col_v [N];
  logic [N*LLR_W-1:0] col_e [N];

  logic [NN*LLR_W-1:0] ext_r_flat, ext_c_flat;

  spc_ctrl #(.N(N), .ITER_W(ITER_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .llr_valid(llr_valid),
    .iters_in(iters_in), .load_go(load_go), .load_we(load_we),
    .load_idx(load_idx), .row_step(row_step), .col_step(col_step),
    .dec_step(dec_step), .it_cnt(it_cnt), .iters_q(iters_q)
  );

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_bit
      assign row_v[r][c*LLR_W +: LLR_W] = sat_add(chan[r*N+c], ext_c[r*N+c]);
      assign col_v[c][r*LLR_W +: LLR_W] = sat_add(chan[r*N+c], ext_r[r*N+c]);
      assign ext_r_flat[(r*N+c)*LLR_W +: LLR_W] = ext_r[r*N+c];
      assign ext_c_flat[(r*N+c)*LLR_W +: LLR_W] = ext_c[r*N+c];
    end
    spc_minsum #(.N(N)) u_row (.v_flat(row_v[r]), .e_flat(row_e[r]));
    spc_minsum #(.N(N)) u_col (.v_flat(col_v[r]), .e_flat(col_e[r]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NN; k++) begin
        chan[k]  <= '0;
        ext_r[k] <= '0;
        ext_c[k] <= '0;
      end
      hard_out <= '0;
      done     <= 1'b0;
    end else begin
      done <= dec_step;
      for (int k = 0; k < NN; k++) begin
        if (load_go) begin
          ext_r[k] <= '0;
          ext_c[k] <= '0;
        end
        if (row_step) ext_r[k] <= row_e[k/N][(k%N)*LLR_W +: LLR_W];
        if (col_step) ext_c[k] <= col_e[k%N][(k/N)*LLR_W +: LLR_W];
        if (dec_step) hard_out[k] <= decide(chan[k], ext_r[k], ext_c[k]);
      end
      if (load_we) chan[load_idx] <= sat_add(llr_in, '0);
    end
  end
endmodule

// File: rtl/spc_prod_decoder_chk.sv
module spc_prod_decoder_chk
  import spc_pkg::*;
#(
  parameter int N      = 4,
  parameter int ITER_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  done,
  input logic                  load_go,
  input logic                  row_step,
  input logic                  col_step,
  input logic                  dec_step,
  input logic [ITER_W-1:0]     it_cnt,
  input logic [ITER_W-1:0]     iters_q,
  input logic [N*N*LLR_W-1:0]  ext_r_flat,
  input logic [N*N*LLR_W-1:0]  ext_c_flat,
  input logic [N*N-1:0]        hard_out
);
  a_r1_ext_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> (ext_r_flat == '0 && ext_c_flat == '0));

  a_r4_row_then_col: assert property (@(posedge clk) disable iff (!rst_n)
    row_step |=> col_step);

  a_r7_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    col_step |-> (it_cnt < iters_q));

  a_r7_decide_at_count: assert property (@(posedge clk) disable iff (!rst_n)
    dec_step |-> (it_cnt == iters_q));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_hard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_step |=> $stable(hard_out));

  for (genvar k = 0; k < N*N; k++) begin : g_sat
    a_r5_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_r_flat[k*LLR_W +: LLR_W] != {1'b1, {(LLR_W-1){1'b0}}}) &&
      (ext_c_flat[k*LLR_W +: LLR_W] != {1'b1, {(LLR_W-1){1'b0}}}));
  end
endmodule

bind spc_prod_decoder spc_prod_decoder_chk #(.N(N), .ITER_W(ITER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .load_go(load_go),
  .row_step(row_step), .col_step(col_step), .dec_step(dec_step),
  .it_cnt(it_cnt), .iters_q(iters_q), .ext_r_flat(ext_r_flat),
  .ext_c_flat(ext_c_flat), .hard_out(hard_out)
);

// File: tb/spc_prod_decoder_test.sv
module spc_prod_decoder_test;
  localparam int N  = 4;
  localparam int NN = N * N;
  localparam int VMAX = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  iters_in = '0;
  logic        llr_valid = 1'b0;
  logic [5:0]  llr_in = '0;
  logic        done;
  logic [NN-1:0] hard_out;

  int n_tests = 0;
  int n_fail  = 0;
  int frame [NN];
  int ch [NN];
  int er [NN];
  int ec [NN];
  int lat;
  bit finished = 0;

  always #10 clk = ~clk;

  spc_prod_decoder #(.N(N), .ITER_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .iters_in(iters_in),
    .llr_valid(llr_valid), .llr_in(llr_in), .done(done), .hard_out(hard_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    if (v > VMAX) return VMAX;
    if (v < -VMAX) return -VMAX;
    return v;
  endfunction

  // one code update: out[j] from in[] of the other members only
  task automatic code_update(input int inv [N], output int outv [N]);
    for (int j = 0; j < N; j++) begin
      int negs = 0;
      int m = 1000;
      for (int o = 0; o < N; o++) begin
        if (o == j) continue;
        if (inv[o] < 0) negs++;
        if ((inv[o] < 0 ? -inv[o] : inv[o]) < m) m = (inv[o] < 0 ? -inv[o] : inv[o]);
      end
      outv[j] = (negs % 2) ? -m : m;
    end
  endtask

  task automatic model(input int iters, output logic [NN-1:0] expv);
    int tin [N];
    int tout [N];
    for (int k = 0; k < NN; k++) begin
      ch[k] = clampv(frame[k]);
      er[k] = 0;
      ec[k] = 0;
    end
    for (int it = 0; it < iters; it++) begin
      for (int r = 0; r < N; r++) begin
        for (int c = 0; c < N; c++) tin[c] = clampv(ch[r*N+c] + ec[r*N+c]);
        code_update(tin, tout);
        for (int c = 0; c < N; c++) er[r*N+c] = tout[c];
      end
      for (int c = 0; c < N; c++) begin
        for (int r = 0; r < N; r++) tin[r] = clampv(ch[r*N+c] + er[r*N+c]);
        code_update(tin, tout);
        for (int r = 0; r < N; r++) ec[r*N+c] = tout[r];
      end
    end
    for (int k = 0; k < NN; k++) expv[k] = (ch[k] + er[k] + ec[k]) > 0;
  endtask

  // drives one frame; lat = negedges from last word until done seen
  task automatic run_frame(input int iters, input bit disturb_iters);
    @(negedge clk);
    start = 1'b1;
    iters_in = 4'(iters);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < NN; k++) begin
      llr_valid = 1'b1;
      llr_in = 6'(frame[k]);
      if (disturb_iters) iters_in = 4'(iters + 3);
      @(negedge clk);
    end
    llr_valid = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_and_compare(input int iters, input string req);
    logic [NN-1:0] expv;
    model(iters, expv);
    run_frame(iters, 0);
    check(hard_out == expv, req, hard_out, expv);
  endtask

  initial begin
    logic [NN-1:0] expv;
    logic [NN-1:0] cw;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && hard_out == '0, "R7 reset state", {done, hard_out}, 0);
    rst_n = 1'b1;

    // R1 R2: zero iterations, order and sign convention incl. zero and -32
    for (int t = 0; t < 6; t++) begin
      for (int k = 0; k < NN; k++) frame[k] = $urandom_range(0, 63) - 32;
      frame[t] = 0;
      frame[(t + 5) % NN] = -32;
      for (int k = 0; k < NN; k++) expv[k] = frame[k] > 0;
      run_frame(0, 0);
      check(hard_out == expv, "R1 R2 zero-iteration hard decision", hard_out, expv);
      check(lat == 1, "R7 latency at zero iterations", lat, 1);
    end

    // R3 R4 R6: random frames against the exclusion model
    for (int t = 0; t < 60; t++) begin
      int it = 1 + (t % 4);
      for (int k = 0; k < NN; k++) frame[k] = $urandom_range(0, 40) - 20;
      run_and_compare(it, "R3 R4 R6 random frame vs model");
      check(lat == 2 * it + 1, "R7 latency", lat, 2 * it + 1);
      @(negedge clk);
      check(done == 1'b0, "R7 done single cycle", done, 0);
    end

    // R5: saturating extremes
    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < NN; k++) frame[k] = ($urandom_range(0, 1) ? 31 : -32);
      if (t == 0) for (int k = 0; k < NN; k++) frame[k] = -32;
      run_and_compare(1 + (t % 3), "R5 saturation frame vs model");
    end

    // R3: one weak member, its own extrinsic must not use itself
    for (int k = 0; k < NN; k++) frame[k] = 12;
    frame[5] = -2;
    run_and_compare(1, "R3 own value excluded");
    check(hard_out[5] == 1'b1, "R3 weak bit flipped by others", hard_out[5], 1);

    // R7: iteration count taken at start, later changes ignored
    for (int k = 0; k < NN; k++) frame[k] = $urandom_range(0, 40) - 20;
    model(2, expv);
    run_frame(2, 1);
    check(lat == 5, "R7 count sampled at start", lat, 5);
    check(hard_out == expv, "R7 result with disturbed count", hard_out, expv);
    iters_in = '0;

    // R8: every single-error position, several error magnitudes
    for (int pos = 0; pos < NN; pos++) begin
      for (int em = 1; em <= 15; em += 7) begin
        cw = '0;
        for (int r = 0; r < N - 1; r++)
          for (int c = 0; c < N - 1; c++) cw[r*N+c] = $urandom_range(0, 1);
        for (int r = 0; r < N - 1; r++) begin
          cw[r*N+N-1] = 1'b0;
          for (int c = 0; c < N - 1; c++) cw[r*N+N-1] ^= cw[r*N+c];
        end
        for (int c = 0; c < N; c++) begin
          cw[(N-1)*N+c] = 1'b0;
          for (int r = 0; r < N - 1; r++) cw[(N-1)*N+c] ^= cw[r*N+c];
        end
        for (int k = 0; k < NN; k++) begin
          int m = 8 + $urandom_range(0, 7);
          frame[k] = cw[k] ? m : -m;
        end
        frame[pos] = cw[pos] ? -em : em;
        run_frame(1, 0);
        check(hard_out == cw, "R8 single error corrected", hard_out, cw);
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule